// File: doc/BRIEF.md
# Palette Look-Up Table with Host/Display Arbitration

This block holds a 256-entry palette of 16-bit colors and shares it between a host register interface and a pixel display pipeline. The host sees three registers: a control register, a write-data register and a read-data register. The control register carries a palette enable, a hardware busy flag, a read trigger, a host-ownership bit and an 8-bit entry address. While host ownership is set, the host may write entries (by writing the write-data register) and read entries (by raising the read trigger). Each access holds the busy flag for a fixed number of cycles before it completes. While host ownership is clear, the display pipeline owns the table.

On the display side an 8-bit palette index enters every cycle and a 16-bit color leaves one cycle later. The color comes from the table when the palette is enabled and the display owns it. Otherwise the index is passed through zero-extended, with the same one-cycle latency.

Top module: `palette_lut`

## Requirements
- R1: After reset the control register (offset 0) and the read-data register (offset 2) read as zero.
- R2: Control bits 13..10 always read as zero. Host writes to bit 14 (busy) have no effect on it.
- R3: A write to the write-data register (offset 1) while control bit 8 is set and busy is low raises busy (bit 14) for exactly two cycles. When busy falls, the entry selected by bits 7..0 holds the written value.
- R4: A control write that sets bit 9 (read trigger) while bit 9 was clear, with bit 8 set in the written value and busy low, raises busy for exactly two cycles. When busy falls, the read-data register holds the selected entry.
- R5: The read trigger does not clear itself. A control write that keeps bit 9 set starts no new read.
- R6: A write-data write or a trigger while bit 8 is clear is ignored: busy stays low and no entry changes.
- R7: With bit 15 set and bit 8 clear, the display color one cycle after an index is presented equals the table entry at that index.
- R8: With bit 15 clear or bit 8 set, the display color one cycle after an index is presented equals the index zero-extended to 16 bits.
- R9: A write-data write or a new trigger that arrives while busy is high starts no access.
- R10: The write-data register reads back the last value written to it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWrEn | input | 1 | Host register write strobe |
| regAddr | input | 2 | Register select: 0 control, 1 write data, 2 read data |
| regWrData | input | 16 | Host write value |
| regRdData | output | 16 | Value of the selected register |
| pixIndex | input | 8 | Display palette index |
| pixColor | output | 16 | Display color, one cycle after the index |

## Verification
The hardest case to reach from the ports is a host request that lands inside the two-cycle busy window. To make it, the bench issues a second write-data write, or a fresh trigger edge, on the cycle right after the first one. It then reads the entry back later to show the second request left nothing behind. The trigger's edge-only behavior is also forced: the bench rewrites the control register with bit 9 still set and watches busy stay low. A full sweep writes all 256 entries with an arithmetic pattern. It reads each one back through the trigger and then through the display path.

// File: rtl/palette_pkg.sv
package palette_pkg;
  localparam int IDX_W   = 8;
  localparam int COLOR_W = 16;
  localparam int DEPTH   = 1 << IDX_W;

  localparam logic [1:0] REG_CTRL  = 2'd0;
  localparam logic [1:0] REG_WDATA = 2'd1;
  localparam logic [1:0] REG_RDATA = 2'd2;

  // control bit positions
  localparam int BIT_EN   = 15;
  localparam int BIT_BUSY = 14;
  localparam int BIT_TRIG = 9;
  localparam int BIT_OWN  = 8;

  typedef struct packed {
    logic               doWrite;
    logic               doRead;
    logic [IDX_W-1:0]   addr;
    logic [COLOR_W-1:0] wdata;
  } lutStrobe_t;
endpackage

// File: rtl/palette_ctrl.sv
module palette_ctrl
  import palette_pkg::*;
#(
  parameter int BUSY_CYCLES = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               regWrEn,
  input  logic [1:0]         regAddr,
  input  logic [15:0]        regWrData,
  input  logic [COLOR_W-1:0] rdData,
  output logic [15:0]        regRdData,
  output lutStrobe_t         strobe,
  output logic               enQ,
  output logic               ownQ,
  output logic               busy
);
  localparam int CNT_W = $clog2(BUSY_CYCLES + 1);

  logic               trigQ;
  logic [IDX_W-1:0]   addrQ;
  logic [COLOR_W-1:0] wdataQ;
  logic [CNT_W-1:0]   cnt;
  logic               opWrite;
  logic [IDX_W-1:0]   opAddr;
  logic [COLOR_W-1:0] opData;

  logic ctrlWr, dataWr, startRead, startWrite;

  assign ctrlWr     = regWrEn && (regAddr == REG_CTRL);
  assign dataWr     = regWrEn && (regAddr == REG_WDATA);
  assign busy       = (cnt != '0);
  assign startRead  = ctrlWr && regWrData[BIT_TRIG] && !trigQ && regWrData[BIT_OWN] && !busy;
  assign startWrite = dataWr && ownQ && !busy;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enQ     <= 1'b0;
      ownQ    <= 1'b0;
      trigQ   <= 1'b0;
      addrQ   <= '0;
      wdataQ  <= '0;
      cnt     <= '0;
      opWrite <= 1'b0;
      opAddr  <= '0;
      opData  <= '0;
    end else begin
      if (ctrlWr) begin
        enQ   <= regWrData[BIT_EN];
        ownQ  <= regWrData[BIT_OWN];
        trigQ <= regWrData[BIT_TRIG];
        addrQ <= regWrData[IDX_W-1:0];
      end
      if (dataWr) wdataQ <= regWrData[COLOR_W-1:0];
      if (startRead || startWrite) begin
        cnt     <= CNT_W'(BUSY_CYCLES);
        opWrite <= startWrite;
        opAddr  <= startRead ? regWrData[IDX_W-1:0] : addrQ;
        opData  <= regWrData[COLOR_W-1:0];
      end else if (busy) begin
        cnt <= cnt - 1'b1;
      end
    end
  end

  logic fire;
  assign fire = (cnt == CNT_W'(1));

  always_comb begin
    strobe.doWrite = fire && opWrite;
    strobe.doRead  = fire && !opWrite;
    strobe.addr    = opAddr;
    strobe.wdata   = opData;
  end

  always_comb begin
    unique case (regAddr)
      REG_CTRL:  regRdData = {enQ, busy, 4'b0000, trigQ, ownQ, addrQ};
      REG_WDATA: regRdData = wdataQ;
      REG_RDATA: regRdData = rdData;
      default:   regRdData = '0;
    endcase
  end
endmodule

// File: rtl/palette_datapath.sv
module palette_datapath
  import palette_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  lutStrobe_t         strobe,
  input  logic               useTable,
  input  logic [IDX_W-1:0]   pixIndex,
  output logic [COLOR_W-1:0] rdData,
  output logic [COLOR_W-1:0] pixColor
);
  logic [COLOR_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (strobe.doWrite) mem[strobe.addr] <= strobe.wdata;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdData   <= '0;
      pixColor <= '0;
    end else begin
      if (strobe.doRead) rdData <= mem[strobe.addr];
      pixColor <= useTable ? mem[pixIndex] : COLOR_W'(pixIndex);
    end
  end
endmodule

// File: rtl/palette_lut.sv
module palette_lut
  import palette_pkg::*;
#(
  parameter int BUSY_CYCLES = 2
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         regWrEn,
  input  logic [1:0]   regAddr,
  input  logic [15:0]  regWrData,
  output logic [15:0]  regRdData,
  input  logic [7:0]   pixIndex,
  output logic [15:0]  pixColor
);
  lutStrobe_t         strobe;
  logic               enQ, ownQ, busy;
  logic [COLOR_W-1:0] rdData;

  palette_ctrl #(.BUSY_CYCLES(BUSY_CYCLES)) uCtrl (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .rdData(rdData), .regRdData(regRdData),
    .strobe(strobe), .enQ(enQ), .ownQ(ownQ), .busy(busy)
  );

  palette_datapath uData (
    .clk(clk), .rstN(rstN), .strobe(strobe), .useTable(enQ && !ownQ),
    .pixIndex(pixIndex), .rdData(rdData), .pixColor(pixColor)
  );
endmodule

// File: rtl/palette_lut_chk.sv
module palette_lut_chk (
  input logic        clk,
  input logic        rstN,
  input logic        regWrEn,
  input logic [1:0]  regAddr,
  input logic [15:0] regWrData,
  input logic [15:0] regRdData,
  input logic [7:0]  pixIndex,
  input logic [15:0] pixColor,
  input logic        busy,
  input logic        enQ,
  input logic        ownQ,
  input logic        doWrite,
  input logic        doRead
);
  assert_unimpl_zero_R2: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr == 2'd0) |-> (regRdData[13:10] == 4'b0000));

  assert_busy_two_R3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |=> busy);

  assert_busy_ends_R4: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy)) |=> !busy);

  assert_unowned_ignored_R6: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regAddr == 2'd1 && !ownQ && !busy) |=> !busy);

  assert_no_retrigger_R5: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regAddr == 2'd0 && regAddr == 2'd0 && regRdData[9] && regWrData[9] && !busy) |=> !busy);

  assert_passthru_R8: assert property (@(posedge clk) disable iff (!rstN)
    (!enQ || ownQ) |=> (pixColor == {8'h00, $past(pixIndex)}));

  assert_one_op_R9: assert property (@(posedge clk) disable iff (!rstN)
    !(doWrite && doRead));

  assert_strobe_in_busy_R3: assert property (@(posedge clk) disable iff (!rstN)
    (doWrite || doRead) |-> busy);
endmodule

bind palette_lut palette_lut_chk uChk (
  .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
  .regWrData(regWrData), .regRdData(regRdData), .pixIndex(pixIndex),
  .pixColor(pixColor), .busy(busy), .enQ(enQ), .ownQ(ownQ),
  .doWrite(strobe.doWrite), .doRead(strobe.doRead)
);

// File: tb/tb_palette_lut.sv
module tb_palette_lut;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic [1:0]  regAddr = 2'd0;
  logic [15:0] regWrData = '0;
  logic [15:0] regRdData;
  logic [7:0]  pixIndex = '0;
  logic [15:0] pixColor;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  palette_lut dut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData),
    .pixIndex(pixIndex), .pixColor(pixColor)
  );

  function automatic logic [15:0] pattern(input int i);
    logic [15:0] v;
    v = 16'(i * 16'h9E37);
    return v ^ 16'hA5C3;
  endfunction

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic regWrite(input logic [1:0] a, input logic [15:0] d);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0; regAddr = 2'd0;
  endtask

  function automatic logic [15:0] ctrlWord(input bit en, input bit trig, input bit own, input int a);
    return {en, 1'b0, 4'b0000, trig, own, 8'(a)};
  endfunction

  function automatic logic busyNow();
    return regRdData[14];
  endfunction

  task automatic readEntry(input int a, output logic [15:0] v);
    regWrite(2'd0, ctrlWord(0, 0, 1, a));
    regWrite(2'd0, ctrlWord(0, 1, 1, a));
    @(negedge clk); @(negedge clk);
    regAddr = 2'd2; #0;
    v = regRdData;
    regAddr = 2'd0;
  endtask

  task automatic writeEntry(input int a, input logic [15:0] d);
    regWrite(2'd0, ctrlWord(0, 0, 1, a));
    regWrite(2'd1, d);
    @(negedge clk); @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=%h expected=%h", 16'd0, 16'd1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    @(negedge clk); @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    regAddr = 2'd0; #1; check("R1 ctrl", regRdData, 16'h0000);
    regAddr = 2'd2; #1; check("R1 rdata", regRdData, 16'h0000);
    regAddr = 2'd0;

    // R2 reserved bits read zero, busy not writable
    regWrite(2'd0, 16'hFC00);
    #1; check("R2 ctrl", regRdData, 16'h8000);
    regWrite(2'd0, 16'h0000);

    // R10 write-data readback
    regWrite(2'd1, 16'h1234);
    regAddr = 2'd1; #1; check("R10 wdata", regRdData, 16'h1234);
    regAddr = 2'd0;

    // R6 write while not owned: no busy
    #1; check("R6 busy", {15'd0, busyNow()}, 16'd0);
    regWrite(2'd0, ctrlWord(0, 1, 0, 5));  // trigger without ownership
    #1; check("R6 trig busy", {15'd0, busyNow()}, 16'd0);
    regWrite(2'd0, 16'h0000);

    // R3 busy exactly two cycles on write
    regWrite(2'd0, ctrlWord(0, 0, 1, 7));
    regWrite(2'd1, 16'hBEEF);
    #1; check("R3 busy c1", {15'd0, busyNow()}, 16'd1);
    @(negedge clk); #1; check("R3 busy c2", {15'd0, busyNow()}, 16'd1);
    @(negedge clk); #1; check("R3 busy low", {15'd0, busyNow()}, 16'd0);

    // R4 busy two cycles on read, then data
    regWrite(2'd0, ctrlWord(0, 1, 1, 7));
    #1; check("R4 busy c1", {15'd0, busyNow()}, 16'd1);
    @(negedge clk); #1; check("R4 busy c2", {15'd0, busyNow()}, 16'd1);
    @(negedge clk); #1; check("R4 busy low", {15'd0, busyNow()}, 16'd0);
    regAddr = 2'd2; #1; check("R4 rdata", regRdData, 16'hBEEF);
    regAddr = 2'd0;

    // R5 trigger stays set, rewrite with trig set starts nothing
    #1; check("R5 trig held", {15'd0, regRdData[9]}, 16'd1);
    regWrite(2'd0, ctrlWord(0, 1, 1, 7));
    #1; check("R5 no busy", {15'd0, busyNow()}, 16'd0);

    // R6 write-data while not owned leaves entry unchanged
    regWrite(2'd0, ctrlWord(0, 0, 0, 7));
    regWrite(2'd1, 16'h0BAD);
    #1; check("R6 no busy", {15'd0, busyNow()}, 16'd0);
    readEntry(7, v); check("R6 entry kept", v, 16'hBEEF);

    // R9 requests during busy are ignored
    regWrite(2'd0, ctrlWord(0, 0, 1, 9));
    regWrite(2'd1, 16'h1111);
    regWrite(2'd1, 16'h2222);   // arrives during busy
    @(negedge clk);
    readEntry(9, v); check("R9 write in busy", v, 16'h1111);
    regWrite(2'd0, ctrlWord(0, 0, 1, 7));
    regWrite(2'd1, 16'h3333);   // write to 7 starts busy
    regWrite(2'd0, ctrlWord(0, 1, 1, 9)); // trigger during busy
    @(negedge clk);
    regAddr = 2'd2; #1; check("R9 read in busy", regRdData, 16'h1111);
    regAddr = 2'd0;

    // Full sweep: write all entries (R3), read back via trigger (R4)
    for (int i = 0; i < 256; i++) writeEntry(i, pattern(i));
    for (int i = 0; i < 256; i++) begin
      readEntry(i, v);
      check("R4 sweep", v, pattern(i));
    end

    // R7 display through table
    regWrite(2'd0, ctrlWord(1, 0, 0, 0));
    for (int i = 0; i < 256; i++) begin
      pixIndex = 8'(i);
      @(negedge clk);
      check("R7 lookup", pixColor, pattern(i));
    end

    // R8 pass-through when disabled
    regWrite(2'd0, ctrlWord(0, 0, 0, 0));
    for (int i = 0; i < 256; i += 3) begin
      pixIndex = 8'(i);
      @(negedge clk);
      check("R8 disabled", pixColor, {8'h00, 8'(i)});
    end

    // R8 pass-through when host owns the table
    regWrite(2'd0, ctrlWord(1, 0, 1, 0));
    for (int i = 1; i < 256; i += 5) begin
      pixIndex = 8'(i);
      @(negedge clk);
      check("R8 host owned", pixColor, {8'h00, 8'(i)});
    end

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule